// File: doc/BRIEF.md
# Overlapping-Window Thread Register File

This block holds the general registers of several hardware threads, each organised as a ring of register windows. A program sees 24 windowed registers at a time: eight outgoing, eight local and eight incoming. A call strobe moves the selected thread to the next window, so the eight registers the caller filled as outgoing arguments become the callee's incoming registers. A return strobe moves back, so values the callee leaves in its incoming registers appear in the caller's outgoing registers. Nothing is copied and no memory traffic is needed to pass parameters or results.

Physically each thread owns NWIN windows of sixteen registers: eight locals and one out bank that the next window reads as its in bank. Windows wrap modulo NWIN. A per-thread depth counter flags a call that would reuse the oldest live bank (overflow) and a return below the oldest live window (underflow). In either case the pointer stays put and a one-cycle trap pulse is raised. Two combinational read ports and one write port share the thread select. A write becomes stored at the clock edge, and a same-cycle read of the register being written returns the new data.

Top module: `win_regfile`

## Requirements
- R1: After reset every thread sits at window 0 with call depth 0, and both trap outputs are low.
- R2: Register number 8-15 selects an outgoing, 16-23 a local and 24-31 an incoming register of the current window. Numbers 0-7 read as zero, and writes to them change nothing.
- R3: After an accepted call, incoming register 24+k reads the value the caller held in outgoing register 8+k.
- R4: After the matching return, the caller's outgoing register 8+k holds what the callee wrote to incoming register 24+k. The caller's locals and incoming registers are unchanged by anything the callee wrote.
- R5: A call made when the thread is already NWIN-2 calls deep raises `ovfTrap` for exactly one cycle, starting the cycle after the strobe, and leaves the window pointer unchanged.
- R6: A return made at call depth 0 raises `unfTrap` for exactly one cycle, starting the cycle after the strobe, and leaves the window pointer unchanged.
- R7: A write is stored at the clock edge. A read of the same register in the same cycle returns the write data on either read port.
- R8: Reads and writes in a cycle that carries a call or return use the window that was current before the strobe. The new window applies from the next cycle.
- R9: Each thread has its own storage, window pointer and depth. `threadId` selects which thread the ports and strobes act on.
- R10: Call and return asserted together do nothing: the pointer does not move and no trap is raised.
- R11: The two read ports decode independent register numbers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of pointers, depths and traps |
| threadId | input | $clog2(THREADS) | Thread addressed by the ports and strobes this cycle |
| callStb | input | 1 | Advance the selected thread's window |
| retStb | input | 1 | Step the selected thread's window back |
| rdAddrA | input | 5 | Register number, read port A |
| rdDataA | output | DATA_W | Read data, port A |
| rdAddrB | input | 5 | Register number, read port B |
| rdDataB | output | DATA_W | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Register number written |
| wrData | input | DATA_W | Write data |
| ovfTrap | output | 1 | One-cycle pulse: call refused, window ring full |
| unfTrap | output | 1 | One-cycle pulse: return refused, no saved window |

## Verification
The window mapping is exercised with distinct value ranges written to outgoing, local and incoming registers. A mix-up between banks therefore shows up as a wrong range rather than a plausible value. A call then a return checks the overlap in both directions, and confirms that callee writes to locals and incoming registers leave the caller's frame alone. Strobes combined with writes and reads in the same cycle tell apart a pointer that changes at the edge from one that changes too early. A second thread driven through a full nest of calls to overflow and back down to underflow, with a tag per window, separates correct refusal from an off-by-one depth limit and shows that threads do not share state.

// File: rtl/win_regfile_pkg.sv
package win_regfile_pkg;

  // Region selected by bits [4:3] of an architectural register number
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_OUT   = 2'd1,
    RGN_LOCAL = 2'd2,
    RGN_IN    = 2'd3
  } regRegion_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrGo;   // write lands in storage this cycle
    logic zeroA;  // port A addresses the read-as-zero range
    logic zeroB;  // port B addresses the read-as-zero range
  } wrfStrobes_t;

endpackage

// File: rtl/win_regfile_ctrl.sv
module win_regfile_ctrl
  import win_regfile_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int NWIN    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(THREADS)-1:0] threadId,
  input  logic                       callStb,
  input  logic                       retStb,
  input  logic                       wrEn,
  input  logic [1:0]                 wrRegion,
  input  logic [1:0]                 rdRegionA,
  input  logic [1:0]                 rdRegionB,
  output wrfStrobes_t                strobes,
  output logic [$clog2(NWIN)-1:0]    curWin,
  output logic                       ovfTrap,
  output logic                       unfTrap
);
  localparam int TID_W = $clog2(THREADS);
  localparam int WIN_W = $clog2(NWIN);
  localparam logic [WIN_W-1:0] LAST_WIN  = WIN_W'(NWIN - 1);
  localparam logic [WIN_W-1:0] DEPTH_MAX = WIN_W'(NWIN - 2);

  logic [WIN_W-1:0] cwpQ   [THREADS];
  logic [WIN_W-1:0] depthQ [THREADS];
  logic [WIN_W-1:0] selDepth;
  logic onlyCall, onlyRet, callGo, retGo;

  always_comb begin
    curWin   = cwpQ[threadId];
    selDepth = depthQ[threadId];
    onlyCall = callStb & ~retStb;
    onlyRet  = retStb & ~callStb;
    callGo   = onlyCall && (selDepth != DEPTH_MAX);
    retGo    = onlyRet && (selDepth != '0);
    strobes.wrGo  = wrEn && (wrRegion != RGN_NONE);
    strobes.zeroA = (rdRegionA == RGN_NONE);
    strobes.zeroB = (rdRegionB == RGN_NONE);
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cwpQ[t]   <= '0;
        depthQ[t] <= '0;
      end else if (threadId == TID_W'(t)) begin
        if (callGo) begin
          cwpQ[t]   <= (cwpQ[t] == LAST_WIN) ? '0 : cwpQ[t] + 1'b1;
          depthQ[t] <= depthQ[t] + 1'b1;
        end else if (retGo) begin
          cwpQ[t]   <= (cwpQ[t] == '0) ? LAST_WIN : cwpQ[t] - 1'b1;
          depthQ[t] <= depthQ[t] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfTrap <= 1'b0;
      unfTrap <= 1'b0;
    end else begin
      ovfTrap <= onlyCall && (selDepth == DEPTH_MAX);
      unfTrap <= onlyRet && (selDepth == '0);
    end
  end

endmodule

// File: rtl/win_regfile_dp.sv
module win_regfile_dp
  import win_regfile_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int THREADS = 4,
  parameter int NWIN    = 8
) (
  input  logic                       clk,
  input  logic [$clog2(THREADS)-1:0] threadId,
  input  logic [$clog2(NWIN)-1:0]    curWin,
  input  wrfStrobes_t                strobes,
  input  logic [4:0]                 rdAddrA,
  input  logic [4:0]                 rdAddrB,
  input  logic [4:0]                 wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdDataA,
  output logic [DATA_W-1:0]          rdDataB
);
  localparam int TID_W   = $clog2(THREADS);
  localparam int WIN_W   = $clog2(NWIN);
  localparam int PER_WIN = 16;
  localparam int PER_THR = NWIN * PER_WIN;
  localparam int DEPTH   = THREADS * PER_THR;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(NWIN - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wrIdx, idxA, idxB;

  // Bank w holds locals at offsets 0-7 and the out bank at 8-15.
  // Window w reads its ins from the out bank of window w-1.
  function automatic logic [IDX_W-1:0] physIdx(
    input logic [TID_W-1:0] tid,
    input logic [WIN_W-1:0] win,
    input logic [4:0]       addr
  );
    regRegion_t       rgn;
    logic [WIN_W-1:0] bank;
    logic [3:0]       off;
    rgn  = regRegion_t'(addr[4:3]);
    bank = win;
    if (rgn == RGN_IN) bank = (win == '0) ? LAST_WIN : win - 1'b1;
    off  = {rgn != RGN_LOCAL, addr[2:0]};
    return IDX_W'(tid) * IDX_W'(PER_THR) + IDX_W'(bank) * IDX_W'(PER_WIN) + IDX_W'(off);
  endfunction

  always_comb begin
    wrIdx = physIdx(threadId, curWin, wrAddr);
    idxA  = physIdx(threadId, curWin, rdAddrA);
    idxB  = physIdx(threadId, curWin, rdAddrB);

    if (strobes.zeroA)                          rdDataA = '0;
    else if (strobes.wrGo && (wrIdx == idxA))   rdDataA = wrData;
    else                                        rdDataA = mem[idxA];

    if (strobes.zeroB)                          rdDataB = '0;
    else if (strobes.wrGo && (wrIdx == idxB))   rdDataB = wrData;
    else                                        rdDataB = mem[idxB];
  end

  always_ff @(posedge clk) begin
    if (strobes.wrGo) mem[wrIdx] <= wrData;
  end

endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import win_regfile_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int THREADS = 4,
  parameter int NWIN    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(THREADS)-1:0] threadId,
  input  logic                       callStb,
  input  logic                       retStb,
  input  logic [4:0]                 rdAddrA,
  output logic [DATA_W-1:0]          rdDataA,
  input  logic [4:0]                 rdAddrB,
  output logic [DATA_W-1:0]          rdDataB,
  input  logic                       wrEn,
  input  logic [4:0]                 wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic                       ovfTrap,
  output logic                       unfTrap
);
  wrfStrobes_t              strobes;
  logic [$clog2(NWIN)-1:0]  curWin;

  win_regfile_ctrl #(.THREADS(THREADS), .NWIN(NWIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .threadId(threadId),
    .callStb(callStb), .retStb(retStb), .wrEn(wrEn),
    .wrRegion(wrAddr[4:3]), .rdRegionA(rdAddrA[4:3]), .rdRegionB(rdAddrB[4:3]),
    .strobes(strobes), .curWin(curWin),
    .ovfTrap(ovfTrap), .unfTrap(unfTrap)
  );

  win_regfile_dp #(.DATA_W(DATA_W), .THREADS(THREADS), .NWIN(NWIN)) u_dp (
    .clk(clk), .threadId(threadId), .curWin(curWin), .strobes(strobes),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int DATA_W  = 32,
  parameter int THREADS = 4,
  parameter int NWIN    = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [$clog2(THREADS)-1:0] threadId,
  input logic                       callStb,
  input logic                       retStb,
  input logic [4:0]                 rdAddrA,
  input logic [DATA_W-1:0]          rdDataA,
  input logic [4:0]                 rdAddrB,
  input logic [DATA_W-1:0]          rdDataB,
  input logic                       wrEn,
  input logic [4:0]                 wrAddr,
  input logic [DATA_W-1:0]          wrData,
  input logic                       ovfTrap,
  input logic                       unfTrap,
  input logic [$clog2(NWIN)-1:0]    curWin
);
  localparam int WIN_W = $clog2(NWIN);
  localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(NWIN - 1);

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA[4:3] == 2'd0) |-> (rdDataA == '0));  // R2
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB[4:3] == 2'd0) |-> (rdDataB == '0));  // R2
  AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == rdAddrA) && (wrAddr[4:3] != 2'd0)) |-> (rdDataA == wrData));  // R7
  AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == rdAddrB) && (wrAddr[4:3] != 2'd0)) |-> (rdDataB == wrData));  // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ovfTrap |-> ($past(callStb) && !$past(retStb)));  // R5
  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    unfTrap |-> ($past(retStb) && !$past(callStb)));  // R6
  AST_NO_BOTH_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfTrap && unfTrap));  // R10
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap && (threadId == $past(threadId))) |-> (curWin == $past(curWin)));  // R5
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (unfTrap && (threadId == $past(threadId))) |-> (curWin == $past(curWin)));  // R6
  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(callStb && !retStb) && !ovfTrap && (threadId == $past(threadId)))
      |-> (curWin == (($past(curWin) == LAST_WIN) ? '0 : $past(curWin) + 1'b1)));  // R3
  AST_BOTH_STILL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(callStb && retStb) && (threadId == $past(threadId))) |-> (curWin == $past(curWin)));  // R10

endmodule

bind win_regfile win_regfile_chk #(.DATA_W(DATA_W), .THREADS(THREADS), .NWIN(NWIN)) u_chk (
  .clk(clk), .rstN(rstN), .threadId(threadId), .callStb(callStb), .retStb(retStb),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .ovfTrap(ovfTrap), .unfTrap(unfTrap), .curWin(curWin)
);

// File: tb/win_regfile_tb.sv
module win_regfile_tb;
  localparam int DATA_W  = 32;
  localparam int THREADS = 4;
  localparam int NWIN    = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        threadId = '0;
  logic              callStb = 1'b0, retStb = 1'b0;
  logic [4:0]        rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdDataA, rdDataB;
  logic              ovfTrap, unfTrap;

  int total = 0;
  int failed = 0;
  logic lastOvf, lastUnf;

  always #4 clk = ~clk;  // 125 MHz

  win_regfile #(.DATA_W(DATA_W), .THREADS(THREADS), .NWIN(NWIN)) u_dut (
    .clk(clk), .rstN(rstN), .threadId(threadId), .callStb(callStb), .retStb(retStb),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ovfTrap(ovfTrap), .unfTrap(unfTrap)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic wr(input logic [1:0] tid, input logic [4:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    threadId = tid; wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] tid, input logic [4:0] a, input logic [4:0] b,
                    output logic [DATA_W-1:0] da, output logic [DATA_W-1:0] db);
    @(negedge clk);
    threadId = tid; rdAddrA = a; rdAddrB = b;
    #1;
    da = rdDataA; db = rdDataB;
  endtask

  // Strobe for one cycle, then capture the trap outputs of the following cycle
  task automatic strobe(input logic [1:0] tid, input logic c, input logic r);
    @(negedge clk);
    threadId = tid; callStb = c; retStb = r;
    @(negedge clk);
    callStb = 1'b0; retStb = 1'b0;
    #1;
    lastOvf = ovfTrap; lastUnf = unfTrap;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] a, b;
    check("R1 ovfTrap after reset", DATA_W'(ovfTrap), '0);
    check("R1 unfTrap after reset", DATA_W'(unfTrap), '0);
    strobe(2'd2, 1'b0, 1'b1);
    check("R1 return at fresh thread underflows", DATA_W'(lastUnf), 1);
    rd(2'd0, 5'd0, 5'd7, a, b);
    check("R2 reg 0 reads zero", a, '0);
    check("R2 reg 7 reads zero", b, '0);
  endtask

  task automatic t_zero();
    logic [DATA_W-1:0] a, b;
    wr(2'd0, 5'd3, 32'hDEAD_0003);
    rd(2'd0, 5'd3, 5'd3, a, b);
    check("R2 write to reg 3 ignored", a, '0);
  endtask

  task automatic t_map();
    logic [DATA_W-1:0] a, b;
    for (int k = 0; k < 8; k++) begin
      wr(2'd0, 5'(8 + k),  32'h100 + k);
      wr(2'd0, 5'(16 + k), 32'h200 + k);
      wr(2'd0, 5'(24 + k), 32'h300 + k);
    end
    for (int k = 0; k < 8; k++) begin
      rd(2'd0, 5'(8 + k), 5'(16 + k), a, b);
      check("R2 out reg", a, 32'h100 + k);
      check("R11 port B local while A reads out", b, 32'h200 + k);
      rd(2'd0, 5'(24 + k), 5'(8 + k), a, b);
      check("R2 in reg", a, 32'h300 + k);
    end
  endtask

  task automatic t_bypass();
    @(negedge clk);
    threadId = 2'd0; wrEn = 1'b1; wrAddr = 5'd9; wrData = 32'h5A5A_0009;
    rdAddrA = 5'd9; rdAddrB = 5'd9;
    #1;
    check("R7 same-cycle bypass port A", rdDataA, 32'h5A5A_0009);
    check("R7 same-cycle bypass port B", rdDataB, 32'h5A5A_0009);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    check("R7 value stored after edge", rdDataA, 32'h5A5A_0009);
    wr(2'd0, 5'd9, 32'h101);
  endtask

  task automatic t_call_ret();
    logic [DATA_W-1:0] a, b;
    strobe(2'd0, 1'b1, 1'b0);
    check("R3 call accepted without trap", DATA_W'(lastOvf), '0);
    for (int k = 0; k < 8; k++) begin
      rd(2'd0, 5'(24 + k), 5'(24 + k), a, b);
      check("R3 callee in shows caller out", a, 32'h100 + k);
    end
    wr(2'd0, 5'd24, 32'hAAA);
    wr(2'd0, 5'd16, 32'h400);
    wr(2'd0, 5'd8,  32'h500);
    strobe(2'd0, 1'b0, 1'b1);
    check("R4 return accepted without trap", DATA_W'(lastUnf), '0);
    rd(2'd0, 5'd8, 5'd9, a, b);
    check("R4 caller out holds callee result", a, 32'hAAA);
    check("R4 untouched out kept", b, 32'h101);
    rd(2'd0, 5'd16, 5'd24, a, b);
    check("R4 caller local intact", a, 32'h200);
    check("R4 caller in intact", b, 32'h300);
  endtask

  task automatic t_order();
    logic [DATA_W-1:0] a, b;
    @(negedge clk);
    threadId = 2'd0; callStb = 1'b1; wrEn = 1'b1; wrAddr = 5'd16; wrData = 32'hBEEF;
    rdAddrA = 5'd24;
    #1;
    check("R8 read in strobe cycle uses old window", rdDataA, 32'h300);
    @(negedge clk);
    callStb = 1'b0; wrEn = 1'b0;
    #1;
    check("R8 new window from next cycle", rdDataA, 32'hAAA);
    rd(2'd0, 5'd16, 5'd16, a, b);
    check("R8 callee local not hit by strobe-cycle write", a, 32'h400);
    @(negedge clk);
    retStb = 1'b1; wrEn = 1'b1; wrAddr = 5'd8; wrData = 32'hCAFE;
    @(negedge clk);
    retStb = 1'b0; wrEn = 1'b0;
    rd(2'd0, 5'd8, 5'd16, a, b);
    check("R8 write in return cycle went to callee", a, 32'hAAA);
    check("R8 write in call cycle went to caller", b, 32'hBEEF);
  endtask

  task automatic t_both();
    logic [DATA_W-1:0] a, b;
    strobe(2'd0, 1'b1, 1'b1);
    check("R10 no overflow on joint strobe", DATA_W'(lastOvf), '0);
    check("R10 no underflow on joint strobe", DATA_W'(lastUnf), '0);
    rd(2'd0, 5'd24, 5'd8, a, b);
    check("R10 window unchanged (in)", a, 32'h300);
    check("R10 window unchanged (out)", b, 32'hAAA);
  endtask

  task automatic t_overflow_underflow();
    logic [DATA_W-1:0] a, b;
    for (int w = 0; w < NWIN - 2; w++) begin
      wr(2'd1, 5'd8, 32'h6000 + w);
      strobe(2'd1, 1'b1, 1'b0);
      check("R5 call within limit no trap", DATA_W'(lastOvf), '0);
    end
    wr(2'd1, 5'd8, 32'h6000 + NWIN - 2);
    strobe(2'd1, 1'b1, 1'b0);
    check("R5 overflow trap raised", DATA_W'(lastOvf), 1);
    @(negedge clk);
    #1;
    check("R5 overflow trap lasts one cycle", DATA_W'(ovfTrap), '0);
    rd(2'd1, 5'd24, 5'd8, a, b);
    check("R5 pointer held (in)", a, 32'h6000 + NWIN - 3);
    check("R5 pointer held (out)", b, 32'h6000 + NWIN - 2);
    for (int w = NWIN - 2; w > 0; w--) begin
      rd(2'd1, 5'd8, 5'd8, a, b);
      check("R9 thread 1 window tag", a, 32'h6000 + w);
      strobe(2'd1, 1'b0, 1'b1);
      check("R6 return within depth no trap", DATA_W'(lastUnf), '0);
    end
    strobe(2'd1, 1'b0, 1'b1);
    check("R6 underflow trap raised", DATA_W'(lastUnf), 1);
    @(negedge clk);
    #1;
    check("R6 underflow trap lasts one cycle", DATA_W'(unfTrap), '0);
    rd(2'd1, 5'd8, 5'd8, a, b);
    check("R6 pointer held at base", a, 32'h6000);
    rd(2'd0, 5'd8, 5'd24, a, b);
    check("R9 thread 0 out unaffected", a, 32'hAAA);
    check("R9 thread 0 in unaffected", b, 32'h300);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_zero();
    t_map();
    t_bypass();
    t_call_ret();
    t_order();
    t_both();
    t_overflow_underflow();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule